// File: doc/BRIEF.md
# Paged Codec Control Register File

This block holds the 16-bit control registers that an audio codec exposes through the command and status slots of its serial link. A register write is a strobe with a 7-bit byte address and a data word. A read is a combinational lookup: the read address goes in and the read data comes out in the same cycle, ready for the status slot. Only even addresses hold registers. The extended window from 60h to 6Eh is shared by two banks, and a page selector field picks which bank answers.

Each register is modelled as storage with a default value and a mask of writable bits. Some registers also carry fixed read-only bits or a side effect. A write to address 00h resets every register to its default. In the power register, status bits are derived from control bits in the same word. Sample-rate registers take writes only while variable-rate mode is enabled. Every register's readback value is also exported on a flat bus so that neighbouring logic can use the settings directly.

Top module: `creg_file`

## Requirements
- R1: Address 00h always reads 6A90h. A write of any value to 00h sets every register, including the page selector, back to its default by the next cycle.
- R2: A synchronous active-high `rst` gives these readbacks: 02h=8000h, 10h=8808h, 18h=8808h, 20h=0000h, 24h=0000h, 26h=000Fh, 28h=0BC7h, 2Ah=05F0h, 2Ch=32h=BB80h. On page 0 it gives 68h=2001h and 6Eh=1000h. On page 1 it gives 62h=FFFFh and 6Eh=3000h.
- R3: Bits 3:0 of 24h select the page. Page 0 maps 68h and 6Eh into the window. Page 1 maps 62h and 6Eh. Any other window address, or any page value other than 0 or 1, reads 0000h and ignores writes. Each bank keeps its contents while the other page is selected.
- R4: In 26h only bits 14:8 are writable. Bit n (n=0..3) reads 1 exactly when bit 8+n is 0. Bits 15 and 7:4 read 0.
- R5: 28h reads 0BC7h, except that bits 5:4 are writable.
- R6: 2Ah reads 05F0h OR'd with its writable bits 15, 14 and 0. Bit 0 is the variable-rate enable.
- R7: Writes to the rate registers 2Ch and 32h are dropped while 2Ah bit 0 is 0. A write that leaves 2Ah bit 0 at 0 returns both rate registers to BB80h.
- R8: In the volume registers 02h, 10h and 18h only bits 15, 12:8, 7 and 4:0 are stored. The other bits read 0.
- R9: In 20h only bits 15, 14, 9, 8 and 7 are stored. The other bits read 0.
- R10: 7Ch and 7Eh read the upper and lower halves of the 32-bit parameter VENDOR_ID and ignore writes.
- R11: Odd addresses and unimplemented even addresses read 0000h, and writes to them change no register.
- R12: A write becomes visible on `rd_data` and `regs_out` in the cycle after the clock edge that samples the strobe, and not before. `regs_out` holds 16-bit readbacks in this slot order, slot 0 in the lowest bits: 02h, 10h, 18h, 20h, 24h, 26h, 28h, 2Ah, 2Ch, 32h, page-0 68h, page-0 6Eh, page-1 62h, page-1 6Eh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 7 | Write byte address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 7 | Read byte address |
| rd_data | output | 16 | Read data (combinational) |
| regs_out | output | 224 | Readback value of every stored register, 16 bits per slot |

## Verification
Errors in the stored state show up on the read port one cycle after the write that caused them. A mask error leaves reserved bits set. A gating error lets a rate value differ from BB80h while variable-rate mode is off. A page-decode error makes a bank value read through the wrong page, or read as zero after the page is switched back. A missed soft reset leaves old values visible on the first read after the write to 00h. Because most of these faults only appear through a specific address and page, the stimulus visits every slot under both pages and re-reads state after page switches and dropped writes.

// File: rtl/creg_pkg.sv
package creg_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 16;
    localparam int NSLOT  = 14;
    localparam int IDX_W  = $clog2(NSLOT);
    localparam int PAGE_W = 4;

    localparam int S_MVOL  = 0;
    localparam int S_LVOL  = 1;
    localparam int S_PVOL  = 2;
    localparam int S_GEN   = 3;
    localparam int S_PAGE  = 4;
    localparam int S_PWR   = 5;
    localparam int S_XID   = 6;
    localparam int S_XCTL  = 7;
    localparam int S_DRATE = 8;
    localparam int S_ARATE = 9;
    localparam int S_P0A   = 10;
    localparam int S_P0B   = 11;
    localparam int S_P1A   = 12;
    localparam int S_P1B   = 13;

    localparam logic [DATA_W-1:0] RESET_WORD = 16'h6A90;
    localparam logic [DATA_W-1:0] RATE_48K   = 16'hBB80;

    typedef enum logic [2:0] {
        AK_NONE, AK_RESET, AK_VID_HI, AK_VID_LO, AK_SLOT
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } acc_t;

    function automatic logic [DATA_W-1:0] dflt_of(int i);
        case (i)
            S_MVOL:            return 16'h8000;
            S_LVOL, S_PVOL:    return 16'h8808;
            S_DRATE, S_ARATE:  return RATE_48K;
            S_P0A:             return 16'h2001;
            S_P0B:             return 16'h1000;
            S_P1A:             return 16'hFFFF;
            S_P1B:             return 16'h3000;
            default:           return 16'h0000;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] wmask_of(int i);
        case (i)
            S_MVOL, S_LVOL, S_PVOL: return 16'h9F9F;
            S_GEN:                  return 16'hC380;
            S_PAGE:                 return 16'h000F;
            S_PWR:                  return 16'h7F00;
            S_XID:                  return 16'h0030;
            S_XCTL:                 return 16'hC001;
            S_P0B:                  return 16'h1FFF;
            S_P1B:                  return 16'hF0FF;
            default:                return 16'hFFFF;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] rofix_of(int i);
        case (i)
            S_XID:   return 16'h0BC7;
            S_XCTL:  return 16'h05F0;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic acc_t mk(acc_kind_e k, int i);
        acc_t r;
        r.kind = k;
        r.idx  = IDX_W'(i);
        return r;
    endfunction

    function automatic acc_t decode(logic [ADDR_W-1:0] a, logic [PAGE_W-1:0] pg);
        case (a)
            7'h00: return mk(AK_RESET, 0);
            7'h02: return mk(AK_SLOT, S_MVOL);
            7'h10: return mk(AK_SLOT, S_LVOL);
            7'h18: return mk(AK_SLOT, S_PVOL);
            7'h20: return mk(AK_SLOT, S_GEN);
            7'h24: return mk(AK_SLOT, S_PAGE);
            7'h26: return mk(AK_SLOT, S_PWR);
            7'h28: return mk(AK_SLOT, S_XID);
            7'h2A: return mk(AK_SLOT, S_XCTL);
            7'h2C: return mk(AK_SLOT, S_DRATE);
            7'h32: return mk(AK_SLOT, S_ARATE);
            7'h7C: return mk(AK_VID_HI, 0);
            7'h7E: return mk(AK_VID_LO, 0);
            7'h68: return (pg == 4'd0) ? mk(AK_SLOT, S_P0A) : mk(AK_NONE, 0);
            7'h62: return (pg == 4'd1) ? mk(AK_SLOT, S_P1A) : mk(AK_NONE, 0);
            7'h6E: begin
                if (pg == 4'd0) return mk(AK_SLOT, S_P0B);
                if (pg == 4'd1) return mk(AK_SLOT, S_P1B);
                return mk(AK_NONE, 0);
            end
            default: return mk(AK_NONE, 0);
        endcase
    endfunction
endpackage

// File: rtl/creg_decode.sv
module creg_decode
    import creg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] page,
    output acc_t              acc
);
    always_comb acc = decode(addr, page);
endmodule

// File: rtl/creg_bank.sv
module creg_bank
    import creg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  acc_t                    wacc,
    input  logic [DATA_W-1:0]       wdata,
    output logic [NSLOT*DATA_W-1:0] view
);
    logic [DATA_W-1:0] q [NSLOT];
    logic soft_rst, vra_on, vra_clr;

    assign soft_rst = we && (wacc.kind == AK_RESET);
    assign vra_on   = q[S_XCTL][0];
    assign vra_clr  = we && (wacc.kind == AK_SLOT) && (int'(wacc.idx) == S_XCTL) && !wdata[0];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NSLOT; i++) begin
            if (rst || soft_rst) begin
                q[i] <= dflt_of(i) & wmask_of(i);
            end else if ((i == S_DRATE || i == S_ARATE) && vra_clr) begin
                q[i] <= RATE_48K;
            end else if (we && wacc.kind == AK_SLOT && int'(wacc.idx) == i) begin
                if (!((i == S_DRATE || i == S_ARATE) && !vra_on))
                    q[i] <= wdata & wmask_of(i);
            end
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_view
        if (g == S_PWR) begin : g_rdy
            assign view[g*DATA_W +: DATA_W] = q[g] | {12'h000, ~q[g][11:8]};
        end else begin : g_plain
            assign view[g*DATA_W +: DATA_W] = q[g] | rofix_of(g);
        end
    end
endmodule

// File: rtl/creg_file.sv
module creg_file
    import creg_pkg::*;
#(
    parameter logic [31:0] VENDOR_ID = 32'h4C5A_1E07
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    output logic [NSLOT*DATA_W-1:0] regs_out
);
    acc_t              wacc, racc;
    logic [PAGE_W-1:0] page;

    assign page = regs_out[S_PAGE*DATA_W +: PAGE_W];

    creg_decode u_wdec (.addr(wr_addr), .page(page), .acc(wacc));
    creg_decode u_rdec (.addr(rd_addr), .page(page), .acc(racc));

    creg_bank u_bank (
        .clk(clk), .rst(rst), .we(wr_en), .wacc(wacc),
        .wdata(wr_data), .view(regs_out)
    );

    always_comb begin
        case (racc.kind)
            AK_RESET:  rd_data = RESET_WORD;
            AK_VID_HI: rd_data = VENDOR_ID[31:16];
            AK_VID_LO: rd_data = VENDOR_ID[15:0];
            AK_SLOT:   rd_data = regs_out[int'(racc.idx)*DATA_W +: DATA_W];
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/creg_file_chk.sv
module creg_file_chk
    import creg_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_en,
    input logic [ADDR_W-1:0]       wr_addr,
    input logic [DATA_W-1:0]       wr_data,
    input logic [ADDR_W-1:0]       rd_addr,
    input logic [DATA_W-1:0]       rd_data,
    input logic [NSLOT*DATA_W-1:0] regs_out
);
    logic [DATA_W-1:0] mvol, page, xid, xctl, drate, arate;
    assign mvol  = regs_out[S_MVOL*DATA_W +: DATA_W];
    assign page  = regs_out[S_PAGE*DATA_W +: DATA_W];
    assign xid   = regs_out[S_XID*DATA_W +: DATA_W];
    assign xctl  = regs_out[S_XCTL*DATA_W +: DATA_W];
    assign drate = regs_out[S_DRATE*DATA_W +: DATA_W];
    assign arate = regs_out[S_ARATE*DATA_W +: DATA_W];

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 7'h00) |=> (mvol == 16'h8000 && page == 16'h0000)); // R1
    AST_RESET_WORD: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 7'h00) |-> (rd_data == 16'h6A90)); // R1
    AST_RATE_LOCK: assert property (@(posedge clk) disable iff (rst)
        (!xctl[0] && wr_en && wr_addr == 7'h2C) |=> $stable(drate)); // R7
    AST_VRA_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 7'h2A && !wr_data[0]) |=> (drate == 16'hBB80 && arate == 16'hBB80)); // R7
    AST_XID_FIXED: assert property (@(posedge clk) disable iff (rst)
        $stable(xid & 16'hFFCF)); // R5
    AST_ODD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[0]) |=> $stable(regs_out)); // R11
    AST_ODD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_addr[0] |-> (rd_data == 16'h0000)); // R11
endmodule

bind creg_file creg_file_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .regs_out(regs_out)
);

// File: tb/creg_file_bench.sv
module creg_file_bench;
    import creg_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    wr_en = 1'b0;
    logic [ADDR_W-1:0]       wr_addr = '0;
    logic [DATA_W-1:0]       wr_data = '0;
    logic [ADDR_W-1:0]       rd_addr = '0;
    logic [DATA_W-1:0]       rd_data;
    logic [NSLOT*DATA_W-1:0] regs_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    creg_file u_creg_file (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .regs_out(regs_out)
    );

    typedef struct packed {
        logic        we;
        logic [6:0]  wa;
        logic [15:0] wd;
        logic [6:0]  ra;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 7'h02, 16'hFFFF, 7'h02, 16'h9F9F, 8'd8},   // R8 volume mask
        '{1'b1, 7'h10, 16'h1234, 7'h10, 16'h1214, 8'd8},   // R8
        '{1'b1, 7'h20, 16'hFFFF, 7'h20, 16'hC380, 8'd9},   // R9
        '{1'b1, 7'h26, 16'hFFFF, 7'h26, 16'h7F00, 8'd4},   // R4 all powered down
        '{1'b1, 7'h26, 16'h0500, 7'h26, 16'h050A, 8'd4},   // R4 mixed
        '{1'b1, 7'h28, 16'hFFFF, 7'h28, 16'h0BF7, 8'd5},   // R5
        '{1'b1, 7'h2C, 16'h1F40, 7'h2C, 16'hBB80, 8'd7},   // R7 dropped
        '{1'b1, 7'h2A, 16'h0001, 7'h2A, 16'h05F1, 8'd6},   // R6
        '{1'b1, 7'h2C, 16'h1F40, 7'h2C, 16'h1F40, 8'd7},   // R7 accepted
        '{1'b1, 7'h32, 16'hAC44, 7'h32, 16'hAC44, 8'd7},   // R7
        '{1'b1, 7'h2A, 16'hC000, 7'h2C, 16'hBB80, 8'd7},   // R7 clear restores
        '{1'b0, 7'h00, 16'h0000, 7'h2A, 16'hC5F0, 8'd6},   // R6
        '{1'b0, 7'h00, 16'h0000, 7'h32, 16'hBB80, 8'd7},   // R7
        '{1'b1, 7'h68, 16'hABCD, 7'h68, 16'hABCD, 8'd3},   // R3 page 0
        '{1'b1, 7'h24, 16'h0001, 7'h68, 16'h0000, 8'd3},   // R3 page 1 hides 68h
        '{1'b1, 7'h6E, 16'hFFFF, 7'h6E, 16'hF0FF, 8'd3},   // R3
        '{1'b0, 7'h00, 16'h0000, 7'h62, 16'hFFFF, 8'd3},   // R3
        '{1'b1, 7'h24, 16'h0000, 7'h6E, 16'h1000, 8'd3},   // R3 bank kept
        '{1'b0, 7'h00, 16'h0000, 7'h68, 16'hABCD, 8'd3},   // R3
        '{1'b1, 7'h24, 16'h0002, 7'h6E, 16'h0000, 8'd3},   // R3 unused page
        '{1'b1, 7'h6E, 16'h1111, 7'h24, 16'h0002, 8'd3},   // R3
        '{1'b1, 7'h24, 16'h0000, 7'h6E, 16'h1000, 8'd3},   // R3 write ignored
        '{1'b1, 7'h03, 16'h0000, 7'h02, 16'h9F9F, 8'd11},  // R11 odd write
        '{1'b0, 7'h00, 16'h0000, 7'h03, 16'h0000, 8'd11},  // R11 odd read
        '{1'b1, 7'h40, 16'hFFFF, 7'h40, 16'h0000, 8'd11},  // R11 unimplemented
        '{1'b1, 7'h7C, 16'h0000, 7'h7C, 16'h4C5A, 8'd10},  // R10
        '{1'b0, 7'h00, 16'h0000, 7'h7E, 16'h1E07, 8'd10},  // R10
        '{1'b1, 7'h00, 16'h0000, 7'h02, 16'h8000, 8'd1},   // R1 soft reset
        '{1'b0, 7'h00, 16'h0000, 7'h2A, 16'h05F0, 8'd1},   // R1
        '{1'b0, 7'h00, 16'h0000, 7'h68, 16'h2001, 8'd1},   // R1
        '{1'b0, 7'h00, 16'h0000, 7'h26, 16'h000F, 8'd1},   // R1
        '{1'b0, 7'h00, 16'h0000, 7'h00, 16'h6A90, 8'd1}    // R1
    };

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input int req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [6:0] a, input logic [15:0] exp, input int req);
        rd_addr = a;
        #1;
        chk(rd_data, exp, req, $sformatf("read %h", a));
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R2 reset state
        rd_chk(7'h00, 16'h6A90, 2);
        rd_chk(7'h02, 16'h8000, 2);
        rd_chk(7'h10, 16'h8808, 2);
        rd_chk(7'h18, 16'h8808, 2);
        rd_chk(7'h20, 16'h0000, 2);
        rd_chk(7'h24, 16'h0000, 2);
        rd_chk(7'h26, 16'h000F, 2);
        rd_chk(7'h28, 16'h0BC7, 2);
        rd_chk(7'h2A, 16'h05F0, 2);
        rd_chk(7'h2C, 16'hBB80, 2);
        rd_chk(7'h32, 16'hBB80, 2);
        rd_chk(7'h68, 16'h2001, 2);
        rd_chk(7'h6E, 16'h1000, 2);
        rd_chk(7'h62, 16'h0000, 2);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VECS[i].we; wr_addr = VECS[i].wa; wr_data = VECS[i].wd;
            rd_addr = VECS[i].ra;
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0;
            #1;
            chk(rd_data, VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
        end

        // R12 timing: not visible before the edge, visible after it, on both outputs
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'h02; wr_data = 16'h0000; rd_addr = 7'h02;
        #1;
        chk(rd_data, 16'h8000, 12, "before edge");
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk(rd_data, 16'h0000, 12, "after edge");
        chk(regs_out[15:0], 16'h0000, 12, "regs_out slot 0");
        chk(regs_out[S_PVOL*16 +: 16], 16'h8808, 12, "regs_out slot 2");

        // R2 hardware reset returns page to 0 and page-1 defaults
        wr(7'h24, 16'h0001);
        wr(7'h6E, 16'h0055);
        @(negedge clk); rst = 1'b1;
        @(posedge clk);
        @(negedge clk); rst = 1'b0;
        rd_chk(7'h24, 16'h0000, 2);
        rd_chk(7'h6E, 16'h1000, 2);
        wr(7'h24, 16'h0001);
        rd_chk(7'h6E, 16'h3000, 2);
        rd_chk(7'h62, 16'hFFFF, 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule